// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block collects up to 32 interrupt sources into one processor interrupt line. Each source is fixed at build time, through a parameter mask, as edge-sensitive or level-sensitive. Captured events sit in a status register. An enable register masks them, and the result is the pending set. A vector register names the lowest-numbered pending source, so a handler can dispatch without scanning the bits itself.

Software reaches the block through a simple word-addressed register port. A write happens in the cycle `bus_wr` is high. Reads have no side effects: `bus_rdata` shows the register selected by `bus_addr` in the same cycle. The port is a control path with no data stream, so it has no valid/ready handshake and never stalls.

A two-bit mode register gates the output line. It also chooses whether the hardware inputs fill the status register or software writes it directly.

Top module: `vic_core`

## Requirements
- R1: After reset, status, enable and mode are zero, `irq_out` is low and the vector (word 6) reads 0xFFFFFFFF.
- R2: Word 1 (pending) reads status AND enable. Writes to word 1 and word 6 change nothing.
- R3: Word 6 reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when none is pending.
- R4: `irq_out` is high exactly when mode bit 0 is 1 and at least one pending bit is set. It follows the registers with no extra delay.
- R5: A write to word 7 (mode) keeps data bits [1:0], and bits [31:2] read as zero. Words 3, 4 and 5 always read zero.
- R6: A write to word 3 clears each status bit whose data bit is 1 and leaves the other status bits as they were.
- R7: Word 2 loads enable directly. Word 4 ORs the data into enable. Word 5 clears the enable bits where the data is 1.
- R8: With mode bit 1 set, every level-sensitive input that is high sets its status bit on each clock, and writes to word 0 are ignored.
- R9: With mode bit 1 clear, a write to word 0 loads status, and no input sets a status bit.
- R10: An edge-sensitive input (mask bit 1) sets its status bit once, on the clock after it is sampled low and then high, and only while mode bit 1 is set. Holding it high after an acknowledge does not set the bit again.
- R11: When a hardware set and an acknowledge hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_irq | input | 32 | Interrupt source inputs |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench targets several corner cases:
- Acknowledging a level source that is still high. A design that lets the clear win would drop a live request.
- Holding an edge source high across an acknowledge. A design that treats the level as an edge would raise the interrupt again forever.
- Writing status in hardware-capture mode, and writing the derived pending and vector words. Either write would corrupt the state if not ignored.
- Two pending bits at once. An encoder that picks the highest bit would return the wrong vector.
- Switching capture off. A design that kept capturing would set bits while software owns the status register.

A long random phase then compares every register read and the output line against a behavioural model on each clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_ENABLE = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VECTOR = 3'd6,
    OFS_MODE   = 3'd7
  } reg_ofs_e;

  localparam int MODE_OUT_BIT = 0;
  localparam int MODE_HW_BIT  = 1;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int               N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             hw_en,
  output logic [N_SRC-1:0] set_o
);
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      assign set_o[g] = hw_en & src[g] & ~src_q[g];
    end else begin : g_level
      assign set_o[g] = hw_en & src[g];
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_SRC = 32,
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |pend;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_SRC-1:0]  hw_set,
  output logic [N_SRC-1:0]  status_o,
  output logic [N_SRC-1:0]  enable_o,
  output logic [1:0]        mode_o
);
  logic [N_SRC-1:0] wsrc;
  logic [N_SRC-1:0] status_d, enable_d;
  logic [1:0]       mode_d;

  assign wsrc = wr_data[N_SRC-1:0];

  always_comb begin
    status_d = status_o;
    enable_d = enable_o;
    mode_d   = mode_o;
    if (wr_en) begin
      unique case (reg_ofs_e'(wr_addr))
        OFS_STATUS: if (!mode_o[MODE_HW_BIT]) status_d = wsrc;
        OFS_ENABLE: enable_d = wsrc;
        OFS_ACK:    status_d = status_o & ~wsrc;
        OFS_SETEN:  enable_d = enable_o | wsrc;
        OFS_CLREN:  enable_d = enable_o & ~wsrc;
        OFS_MODE:   mode_d   = wr_data[1:0];
        default:    ;
      endcase
    end
    status_d = status_d | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      mode_o   <= '0;
    end else begin
      status_o <= status_d;
      enable_o <= enable_d;
      mode_o   <= mode_d;
    end
  end

  assert_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_ACK) |=>
      ((status_o & $past(wsrc & ~hw_set)) == '0));

  assert_seten_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_SETEN) |=> ((enable_o & $past(wsrc)) == $past(wsrc)));

  assert_clren_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_CLREN) |=> ((enable_o & $past(wsrc)) == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_o[MODE_HW_BIT] && !(wr_en && wr_addr == OFS_ACK)) |=>
      (($past(status_o) & ~status_o) == '0));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (|hw_set) |=> ((status_o & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int               N_SRC     = 32,
  parameter int               DATA_W    = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]  hw_set, status, enable, pend;
  logic [1:0]        mode;
  logic              any_pend;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] vector;

  vic_capture #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk   (clk),
    .rst   (rst),
    .src   (src_irq),
    .hw_en (mode[MODE_HW_BIT]),
    .set_o (hw_set)
  );

  vic_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_data  (bus_wdata),
    .hw_set   (hw_set),
    .status_o (status),
    .enable_o (enable),
    .mode_o   (mode)
  );

  assign pend = status & enable;

  vic_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .pend  (pend),
    .any_o (any_pend),
    .idx_o (idx)
  );

  assign vector  = any_pend ? DATA_W'(idx) : '1;
  assign irq_out = mode[MODE_OUT_BIT] & any_pend;

  always_comb begin
    unique case (reg_ofs_e'(bus_addr))
      OFS_STATUS: bus_rdata = DATA_W'(status);
      OFS_PEND:   bus_rdata = DATA_W'(pend);
      OFS_ENABLE: bus_rdata = DATA_W'(enable);
      OFS_VECTOR: bus_rdata = vector;
      OFS_MODE:   bus_rdata = DATA_W'(mode);
      default:    bus_rdata = '0;
    endcase
  end

  assert_vec_low_R3: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |->
      (pend[idx] && ($countones(pend & ((N_SRC'(1) << idx) - N_SRC'(1))) == 0)));

  assert_vec_none_R3: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> (vector == '1));

  assert_irq_R4: assert property (@(posedge clk) disable iff (rst)
    irq_out == (mode[MODE_OUT_BIT] && (vector != '1)));
endmodule

// File: tb/test_vic_core.sv
module test_vic_core;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] src_irq = '0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  localparam logic [31:0] EDGES = 32'hFFFF_0000;

  vic_core #(.N_SRC(32), .DATA_W(32), .EDGE_MASK(EDGES)) i_vic_core (
    .clk(clk), .rst(rst), .src_irq(src_irq), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] m_status = '0, m_enable = '0, m_prev = '0;
  logic [1:0]  m_mode = '0;

  function automatic logic [31:0] m_vector();
    for (int i = 0; i < 32; i++) if (m_status[i] & m_enable[i]) return i;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_status;
      3'd1: return m_status & m_enable;
      3'd2: return m_enable;
      3'd6: return m_vector();
      3'd7: return {30'd0, m_mode};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] s, e, setv;
    if (rst) begin
      m_status = '0; m_enable = '0; m_mode = '0; m_prev = '0;
    end else begin
      setv = '0;
      for (int i = 0; i < 32; i++) begin
        if (m_mode[1] && src_irq[i] && (!EDGES[i] || !m_prev[i])) setv[i] = 1'b1;
      end
      s = m_status; e = m_enable;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: if (!m_mode[1]) s = bus_wdata;
          3'd2: e = bus_wdata;
          3'd3: s = s & ~bus_wdata;
          3'd4: e = e | bus_wdata;
          3'd5: e = e & ~bus_wdata;
          3'd7: m_mode = bus_wdata[1:0];
          default: ;
        endcase
      end
      m_status = s | setv;
      m_enable = e;
      m_prev   = src_irq;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R8 status";
      3'd1: return "R2 pending";
      3'd2: return "R7 enable";
      3'd6: return "R3 vector";
      default: return "R5 ctrl word";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (!rst && !finished) begin
      chk("R4 irq_out", {31'd0, irq_out}, {31'd0, (m_mode[0] && (m_status & m_enable) != 0)});
      chk(addr_tag(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #3;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_rd("R1 vector after reset", 3'd6, 32'hFFFF_FFFF);
    expect_rd("R1 status after reset", 3'd0, 32'h0);
    expect_rd("R1 mode after reset", 3'd7, 32'h0);
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);

    wr(3'd0, 32'h0000_0A00);
    expect_rd("R9 software status load", 3'd0, 32'h0000_0A00);
    wr(3'd4, 32'h0000_0800);
    expect_rd("R2 pending", 3'd1, 32'h0000_0800);
    expect_rd("R3 vector single", 3'd6, 32'd11);
    wr(3'd4, 32'h0000_0200);
    expect_rd("R7 set-enable ORs", 3'd2, 32'h0000_0A00);
    expect_rd("R3 lowest index wins", 3'd6, 32'd9);
    chk("R4 irq gated by mode bit0", {31'd0, irq_out}, 32'd0);
    expect_rd("R5 ack reads zero", 3'd3, 32'h0);
    expect_rd("R5 set-enable reads zero", 3'd4, 32'h0);

    wr(3'd7, 32'hFFFF_FFFF);
    expect_rd("R5 mode keeps two bits", 3'd7, 32'h3);
    chk("R4 irq asserted", {31'd0, irq_out}, 32'd1);
    wr(3'd0, 32'h0);
    expect_rd("R8 status write ignored", 3'd0, 32'h0000_0A00);
    wr(3'd3, 32'h0000_0200);
    expect_rd("R6 ack clears one bit", 3'd0, 32'h0000_0800);
    expect_rd("R3 vector after ack", 3'd6, 32'd11);
    wr(3'd5, 32'h0000_0800);
    expect_rd("R7 clear-enable", 3'd2, 32'h0000_0200);
    expect_rd("R3 nothing pending", 3'd6, 32'hFFFF_FFFF);
    chk("R4 irq drops", {31'd0, irq_out}, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0);
    expect_rd("R2 pending write ignored", 3'd1, 32'h0);
    expect_rd("R2 enable untouched", 3'd2, 32'h0000_0200);

    src_irq[3] = 1'b1;
    idle(2);
    expect_rd("R8 level capture", 3'd0, 32'h0000_0808);
    wr(3'd3, 32'h0000_0008);
    expect_rd("R11 set beats ack", 3'd0, 32'h0000_0808);
    src_irq[3] = 1'b0;
    wr(3'd3, 32'h0000_0008);
    expect_rd("R6 ack after release", 3'd0, 32'h0000_0800);

    src_irq[20] = 1'b1;
    idle(2);
    expect_rd("R10 edge capture", 3'd0, 32'h0010_0800);
    wr(3'd3, 32'h0010_0000);
    idle(3);
    expect_rd("R10 held edge no reset", 3'd0, 32'h0000_0800);
    src_irq[20] = 1'b0;
    idle(1);
    src_irq[20] = 1'b1;
    idle(2);
    expect_rd("R10 second edge", 3'd0, 32'h0010_0800);
    src_irq[20] = 1'b0;

    wr(3'd7, 32'h1);
    src_irq[3] = 1'b1;
    src_irq[25] = 1'b0;
    idle(1);
    src_irq[25] = 1'b1;
    idle(2);
    expect_rd("R9 no capture in software mode", 3'd0, 32'h0010_0800);
    wr(3'd0, 32'h0);
    expect_rd("R9 software clears status", 3'd0, 32'h0);
    src_irq = '0;

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      src_irq   = $urandom() & $urandom();
      bus_wr    = ($urandom() % 3) == 0;
      bus_addr  = 3'($urandom());
      bus_wdata = (($urandom() % 4) == 0) ? 32'hFFFF_FFFF : $urandom();
    end
    @(negedge clk);
    bus_wr = 0;
    idle(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule